// File: doc/BRIEF.md
# Two-Slot Receive Status Register for an OUT Endpoint

This block produces the 8-bit receive status word of one OUT endpoint of a full-speed device controller. Each time the packet engine finishes a packet it pulses a done event together with the packet attributes: SETUP or not, DATA0 or DATA1, error, isochronous mode, end-of-packet seen and the frame number LSB. From these the block forms a four-flag snapshot and stores it.

Two snapshots can be pending at once. A zero-length OUT packet followed at once by a SETUP packet therefore keeps both results. The first read of the word returns the older snapshot and the second read returns the newer one. A read is a one-cycle strobe. The word shown in the strobe cycle is the value read, and the flags of that snapshot are gone after the clock edge. The byte-count field is not stored: it always shows the live receive FIFO occupancy, limited to 15.

The slot queue is a three-state machine:
- `Q_EMPTY`: no snapshot is pending.
- `Q_ONE`: the head slot is valid.
- `Q_TWO`: both slots are valid.

Its transitions:
- Done alone: `Q_EMPTY`→`Q_ONE`, `Q_ONE`→`Q_TWO`, and `Q_TWO`→`Q_TWO`, where the tail is overwritten.
- Read alone: `Q_ONE`→`Q_EMPTY`, `Q_TWO`→`Q_ONE`, where the tail moves to the head. `Q_EMPTY` stays where it is.
- Read and done in the same cycle: `Q_EMPTY`→`Q_ONE`, `Q_ONE`→`Q_ONE` with the new snapshot as head, and `Q_TWO`→`Q_TWO`, where the tail moves to the head and the new snapshot becomes the tail.

Top module: `rx_status_dual`

## Requirements
- R1: The status word is {bit7 error, bit6 setup, bit5 toggle, bit4 last, bits3..0 count}, and the flags come from the oldest pending snapshot.
- R2: Bits 3..0 always show the live FIFO occupancy, or 15 when the occupancy is 15 or more, whatever is pending.
- R3: In non-isochronous mode, the last flag is 1 for a packet without error (ACK sent) and 0 for a packet with error. The error flag copies the packet error.
- R4: In isochronous mode, the last flag copies the end-of-packet-seen input.
- R5: In non-isochronous mode, the toggle flag is 1 for an error-free DATA1 packet, 0 for an error-free DATA0 packet, and 0 for a packet with error.
- R6: In isochronous mode, the toggle flag copies the frame number LSB at the done event.
- R7: A read of the only pending snapshot clears the error, setup, toggle and last flags from the next cycle.
- R8: Two pending snapshots come out in arrival order on successive reads. For example, a zero-length OUT status is followed by a SETUP status.
- R9: A done event while two snapshots are pending replaces the newer one and keeps the older one.
- R10: A read with nothing pending returns zero flags and leaves the block unchanged.
- R11: A read and a done event in the same cycle return the oldest snapshot, and the new snapshot is queued behind whatever remains.
- R12: After reset nothing is pending and the flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_done | input | 1 | One-cycle packet completion event |
| pkt_setup | input | 1 | Completed packet was a SETUP |
| pkt_data1 | input | 1 | Completed packet carried DATA1 |
| pkt_err | input | 1 | Completed packet had an error |
| iso_mode | input | 1 | Endpoint is isochronous |
| eop_seen | input | 1 | End of packet detected |
| frame_lsb | input | 1 | Current frame number LSB |
| fifo_occ | input | OCC_W (7) | Live receive FIFO byte count |
| rd_stb | input | 1 | Status read strobe |
| status | output | 8 | Status word |

## Verification
The count field depends only on `fifo_occ` and changes in the same cycle as it. The flags of a done event appear one clock edge after the event. A read takes effect at the edge that ends its strobe cycle, so the next snapshot or zero flags show up in the following cycle. The bench drives inputs just after the falling edge and compares the word with its queue model two nanoseconds later in the same cycle. It advances the model only after that comparison, so each check sees exactly the edges counted above.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    typedef struct packed {
        logic err;
        logic setup;
        logic tog;
        logic last;
    } rxs_flags_t;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_ONE   = 2'd1,
        Q_TWO   = 2'd2
    } q_state_t;
endpackage

// File: rtl/rxs_capture.sv
module rxs_capture
    import rxs_pkg::*;
(
    input  logic       setup_i,
    input  logic       data1_i,
    input  logic       err_i,
    input  logic       iso_i,
    input  logic       eop_i,
    input  logic       frame_lsb_i,
    output rxs_flags_t flags_o
);
    always_comb begin
        flags_o.err   = err_i;
        flags_o.setup = setup_i;
        if (iso_i) begin
            flags_o.tog  = frame_lsb_i;
            flags_o.last = eop_i;
        end else begin
            flags_o.tog  = data1_i & ~err_i;
            flags_o.last = ~err_i;
        end
    end
endmodule

// File: rtl/rxs_sat.sv
module rxs_sat #(
    parameter int IN_W  = 7,
    parameter int OUT_W = 4
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] sat_o
);
    localparam int MAXV = (1 << OUT_W) - 1;

    generate
        if (IN_W > OUT_W) begin : g_clip
            always_comb begin
                if (val_i > IN_W'(MAXV))
                    sat_o = OUT_W'(MAXV);
                else
                    sat_o = val_i[OUT_W-1:0];
            end
        end else begin : g_pass
            assign sat_o = OUT_W'(val_i);
        end
    endgenerate
endmodule

// File: rtl/rxs_queue.sv
module rxs_queue
    import rxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  logic       pop_i,
    input  rxs_flags_t new_i,
    output rxs_flags_t head_o,
    output q_state_t   state_o
);
    q_state_t   state_q, state_d;
    rxs_flags_t head_q, head_d;
    rxs_flags_t tail_q, tail_d;

    always_comb begin
        state_d = state_q;
        head_d  = head_q;
        tail_d  = tail_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (push_i) begin
                    state_d = Q_ONE;
                    head_d  = new_i;
                end
            end
            Q_ONE: begin
                if (push_i && pop_i) begin
                    head_d = new_i;
                end else if (push_i) begin
                    state_d = Q_TWO;
                    tail_d  = new_i;
                end else if (pop_i) begin
                    state_d = Q_EMPTY;
                    head_d  = '0;
                end
            end
            Q_TWO: begin
                if (push_i && pop_i) begin
                    head_d = tail_q;
                    tail_d = new_i;
                end else if (push_i) begin
                    tail_d = new_i;
                end else if (pop_i) begin
                    state_d = Q_ONE;
                    head_d  = tail_q;
                    tail_d  = '0;
                end
            end
            default: begin
                state_d = Q_EMPTY;
                head_d  = '0;
                tail_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            state_q <= state_d;
            head_q  <= head_d;
            tail_q  <= tail_d;
        end
    end

    always_comb begin
        state_o = state_q;
        if (state_q == Q_EMPTY)
            head_o = '0;
        else
            head_o = head_q;
    end
endmodule

// File: rtl/rx_status_dual.sv
module rx_status_dual
    import rxs_pkg::*;
#(
    parameter int OCC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic             pkt_setup,
    input  logic             pkt_data1,
    input  logic             pkt_err,
    input  logic             iso_mode,
    input  logic             eop_seen,
    input  logic             frame_lsb,
    input  logic [OCC_W-1:0] fifo_occ,
    input  logic             rd_stb,
    output logic [7:0]       status
);
    localparam int CNT_W = 4;

    rxs_flags_t      snap;
    rxs_flags_t      head;
    q_state_t        cur_state;
    logic [CNT_W-1:0] cnt;

    rxs_capture u_cap (
        .setup_i     (pkt_setup),
        .data1_i     (pkt_data1),
        .err_i       (pkt_err),
        .iso_i       (iso_mode),
        .eop_i       (eop_seen),
        .frame_lsb_i (frame_lsb),
        .flags_o     (snap)
    );

    rxs_queue u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (pkt_done),
        .pop_i   (rd_stb),
        .new_i   (snap),
        .head_o  (head),
        .state_o (cur_state)
    );

    rxs_sat #(.IN_W(OCC_W), .OUT_W(CNT_W)) u_sat (
        .val_i (fifo_occ),
        .sat_o (cnt)
    );

    assign status = {head.err, head.setup, head.tog, head.last, cnt};
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker
    import rxs_pkg::*;
#(
    parameter int OCC_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_done,
    input logic             pkt_err,
    input logic             iso_mode,
    input logic             eop_seen,
    input logic [OCC_W-1:0] fifo_occ,
    input logic             rd_stb,
    input logic [7:0]       status,
    input q_state_t         cur_state
);
    p_count_clip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_occ >= OCC_W'(15)) |-> (status[3:0] == 4'hF));

    p_err_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && !iso_mode && pkt_err && !rd_stb && cur_state == Q_EMPTY)
        |=> (status[7] && !status[4]));

    p_iso_eop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && iso_mode && !rd_stb && cur_state == Q_EMPTY)
        |=> (status[4] == $past(eop_seen)));

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == Q_ONE && rd_stb && !pkt_done) |=> (status[7:4] == 4'b0));

    p_keep_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == Q_TWO && pkt_done && !rd_stb) |=> (cur_state == Q_TWO));

    p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == Q_EMPTY && rd_stb && !pkt_done)
        |-> (status[7:4] == 4'b0) ##1 (cur_state == Q_EMPTY));

    p_state_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == Q_EMPTY || cur_state == Q_ONE || cur_state == Q_TWO));
endmodule

bind rx_status_dual rxs_checker #(.OCC_W(OCC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_done  (pkt_done),
    .pkt_err   (pkt_err),
    .iso_mode  (iso_mode),
    .eop_seen  (eop_seen),
    .fifo_occ  (fifo_occ),
    .rd_stb    (rd_stb),
    .status    (status),
    .cur_state (cur_state)
);

// File: tb/sim_rx_status_dual.sv
`timescale 1ns/1ps
module sim_rx_status_dual;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_done = 1'b0, pkt_setup = 1'b0, pkt_data1 = 1'b0, pkt_err = 1'b0;
    logic       iso_mode = 1'b0, eop_seen = 1'b0, frame_lsb = 1'b0, rd_stb = 1'b0;
    logic [6:0] fifo_occ = '0;
    logic [7:0] status;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [3:0] mq[$];

    always #4 clk = ~clk;

    rx_status_dual u0 (
        .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .pkt_setup(pkt_setup),
        .pkt_data1(pkt_data1), .pkt_err(pkt_err), .iso_mode(iso_mode),
        .eop_seen(eop_seen), .frame_lsb(frame_lsb), .fifo_occ(fifo_occ),
        .rd_stb(rd_stb), .status(status)
    );

    function automatic logic [7:0] expect_word(int occ);
        logic [3:0] f;
        logic [3:0] c;
        f = (mq.size() > 0) ? mq[0] : 4'h0;
        c = (occ >= 15) ? 4'hF : 4'(occ);
        return {f, c};
    endfunction

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // One cycle: drive, compare in the same cycle, then advance the model.
    task automatic step(input bit d, input bit s, input bit d1, input bit e,
                        input bit iso, input bit eop, input bit fl,
                        input int occ, input bit rd, input string tag);
        logic [7:0] exp;
        logic [3:0] nf;
        @(negedge clk);
        pkt_done = d; pkt_setup = s; pkt_data1 = d1; pkt_err = e;
        iso_mode = iso; eop_seen = eop; frame_lsb = fl;
        fifo_occ = 7'(occ); rd_stb = rd;
        #2;
        exp = expect_word(occ);
        checks++;
        if (status !== exp) begin
            failures++;
            $display("FAIL %s: status=%02h expected=%02h", tag, status, exp);
        end
        if (rst_n) begin
            nf = {e, s, (iso ? fl : (d1 & ~e)), (iso ? eop : ~e)};
            if (rd && mq.size() > 0) void'(mq.pop_front());
            if (d) begin
                if (mq.size() == 2) mq[1] = nf;
                else mq.push_back(nf);
            end
        end
    endtask

    task automatic idle(input int occ, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, occ, 0, tag);
    endtask

    task automatic rd(input int occ, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, occ, 1, tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                failures++;
                $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, 20000);
                finish_run();
            end
        end
    end

    initial begin
        // R12: reset clears everything; count stays live
        step(1, 1, 1, 1, 0, 0, 0, 3, 0, "R12");
        step(0, 0, 0, 0, 0, 0, 0, 3, 0, "R12");
        @(negedge clk); rst_n = 1'b1;
        idle(0, "R12");

        // R2: saturation of the count field
        for (int k = 0; k < 20; k += 3) idle(k, "R2");
        idle(15, "R2"); idle(16, "R2"); idle(127, "R2");

        // R1 R3 R5: good DATA1 non-ISO packet, then read
        step(1, 0, 1, 0, 0, 0, 0, 8, 0, "R5");
        idle(8, "R1");
        rd(8, "R1");
        idle(8, "R7");

        // R3 R5: error packet kills ACK and toggle
        step(1, 0, 1, 1, 0, 1, 1, 2, 0, "R3");
        idle(2, "R3");
        rd(2, "R3");
        idle(2, "R7");

        // R4 R6: ISO with EOP and frame LSB
        step(1, 0, 0, 0, 1, 1, 1, 20, 0, "R6");
        idle(20, "R4");
        rd(20, "R4");
        step(1, 0, 1, 0, 1, 0, 0, 20, 0, "R4");
        idle(20, "R6");
        rd(20, "R6");

        // R10: read while empty, no effect
        rd(5, "R10");
        rd(5, "R10");
        idle(5, "R10");

        // R8: zero-length OUT then SETUP, read in order
        step(1, 0, 1, 0, 0, 0, 0, 0, 0, "R8");
        step(1, 1, 0, 0, 0, 0, 0, 8, 0, "R8");
        idle(8, "R8");
        rd(8, "R8");
        rd(8, "R8");
        idle(8, "R8");

        // R9: third event overwrites the newer slot
        step(1, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
        step(1, 1, 0, 0, 0, 0, 0, 2, 0, "R9");
        step(1, 0, 1, 1, 0, 0, 0, 3, 0, "R9");
        rd(3, "R9");
        rd(3, "R9");
        idle(3, "R9");

        // R11: simultaneous read and done in each state
        step(1, 1, 0, 0, 0, 0, 0, 4, 1, "R11");
        idle(4, "R11");
        step(1, 0, 1, 0, 0, 0, 0, 4, 1, "R11");
        step(1, 0, 0, 1, 0, 0, 0, 4, 0, "R11");
        step(1, 1, 1, 0, 1, 1, 1, 4, 1, "R11");
        rd(4, "R11");
        rd(4, "R11");
        idle(4, "R11");

        // mixed pattern
        for (int k = 0; k < 40; k++)
            step(k % 3 == 0, k % 2, k % 5 == 1, k % 7 == 2, k % 4 == 3,
                 k % 2 == 0, k % 3 == 1, k, k % 4 == 1, "R1");
        rd(0, "R7"); rd(0, "R7"); idle(0, "R7");

        finish_run();
    end
endmodule